// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a 16-bit processor whose 20-bit address and 16-bit data share one set of lines. Three requesters compete for the bus: a DMA engine, the execution unit and the instruction prefetcher. Each requester holds a request level together with its cycle attributes: address, I/O or memory, read or write, byte or word, and write data. The block grants one requester at a time and runs the granted cycle as a fixed walk through four clock states. The first state puts out the address with a one-clock latch-enable pulse. The second asserts the read or write strobe. The third repeats while the external ready input is low. The fourth releases the strobe and reports completion.

A 3-bit status code says what kind of cycle is in progress, so external logic can tell an opcode fetch from a data read. Prefetch read data goes to a separate queue write port. Data reads made for the execution unit or the DMA engine come back on a shared read-data output, with a done pulse for the requester that owns the cycle. Between cycles the shared lines stay floated if the last cycle was a read, and stay driven with the last write data if it was a write.

Top module: `bus_cycle_seq`

## Requirements
- R1: A granted cycle pulses `ale` for exactly one clock (T1). The strobe for the cycle's direction (`rdN` for reads, `wrN` for writes) is low from the next clock (T2) through the last T3. Both strobes are high in the final clock (T4), and in that same clock exactly one done indication is high.
- R2: `status` is 3'b001 for an I/O read, 3'b010 for an I/O write, 3'b100 for a prefetch read, 3'b101 for a memory read and 3'b110 for a memory write. This holds from T1 through T3. In T4 and while idle, `status` is 3'b111.
- R3: In T1 of an I/O cycle, `adOut[19:16]` is zero and `adOut[15:0]` is the requested address. In T1 of a memory or prefetch cycle, `adOut[19:0]` is the full requested address.
- R4: T3 repeats on every clock edge at which `ready` is low, and `ready` is ignored outside T3. A cycle with N low-ready edges keeps its strobe low for N+2 clocks. For a read, the `adIn` value present at the T3 edge where `ready` is high is the value returned.
- R5: During a read cycle, `adOe` is high in T1 only. It stays low from T2 through T4 and in every idle clock that follows the read.
- R6: During a write cycle, `adOe` is high from T1 through T4, with `adOut` = {4'b0, write data} from T2 on. In the idle clocks after a write, `adOe` stays high and `adOut[15:0]` still carries that write data.
- R7: In idle clocks, `ale` is low and both `rdN` and `wrN` are high. `ale` is high only in T1.
- R8: The grant priority is DMA, then execution unit, then prefetch. A grant is made only when the bus is idle or in T4, so a request raised mid-cycle waits. If another request is pending at T4, its T1 follows in the next clock with no idle clock between.
- R9: Done indications: `dmaDone` is high in the T4 of a DMA cycle, `euDone` in the T4 of an execution-unit cycle, and `pfqWrEn` in the T4 of a prefetch cycle. Prefetch data appears on `pfqData` and never raises `euDone`. Data for the other two requesters appears on `rdData`.
- R10: `bheN` is high for a byte transfer at an even address (address bit 0 = 0). It is low for a word transfer or a byte transfer at an odd address. It holds that value from T1 through T4 and is high while idle.
- R11: While `rstN` is low, the block is idle with `status` = 3'b111, `ale` low, `rdN`, `wrN` and `bheN` high, `adOe` low, and no done indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ready | input | 1 | High ends the wait in T3 |
| dmaReq | input | 1 | DMA request level, held until `dmaDone` |
| dmaIo | input | 1 | DMA cycle targets I/O space |
| dmaWrite | input | 1 | DMA cycle is a write |
| dmaByte | input | 1 | DMA cycle moves one byte |
| dmaAddr | input | 20 | DMA address |
| dmaWdata | input | 16 | DMA write data |
| dmaDone | output | 1 | DMA cycle completes (T4) |
| euReq | input | 1 | Execution-unit request level |
| euIo | input | 1 | Execution-unit cycle targets I/O space |
| euWrite | input | 1 | Execution-unit cycle is a write |
| euByte | input | 1 | Execution-unit cycle moves one byte |
| euAddr | input | 20 | Execution-unit address |
| euWdata | input | 16 | Execution-unit write data |
| euDone | output | 1 | Execution-unit cycle completes (T4) |
| rdData | output | 16 | Read data for DMA and execution unit |
| pfReq | input | 1 | Prefetch request level |
| pfAddr | input | 20 | Prefetch word address |
| pfqWrEn | output | 1 | Prefetch queue write strobe (T4) |
| pfqData | output | 16 | Prefetch queue write data |
| adIn | input | 16 | Data sampled from the shared lines |
| adOut | output | 20 | Value driven on the shared lines |
| adOe | output | 1 | Output enable for the shared lines |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| bheN | output | 1 | Upper byte enable, active low |
| status | output | 3 | Cycle-type status code |

## Verification
The assertions assume that every requester holds its request and attributes steady until its own done indication, and drops the request by the clock edge that closes T4. They also assume the prefetcher only asks for word reads in memory space. The stimulus keeps to these limits. It changes inputs only at the falling clock edge and clears each request in the T4 clock where its done is seen. It holds `ready` high except in the T3 clocks of a cycle with a chosen wait count. It draws directions, spaces, byte selects, addresses and wait counts from a seeded generator. Directed runs add three-way contention, a request raised in mid-cycle, I/O addresses with a nonzero upper nibble, and a long wait.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int STAT_W = 3;

  localparam logic [STAT_W-1:0] CODE_IO_RD   = 3'b001;
  localparam logic [STAT_W-1:0] CODE_IO_WR   = 3'b010;
  localparam logic [STAT_W-1:0] CODE_FETCH   = 3'b100;
  localparam logic [STAT_W-1:0] CODE_MEM_RD  = 3'b101;
  localparam logic [STAT_W-1:0] CODE_MEM_WR  = 3'b110;
  localparam logic [STAT_W-1:0] CODE_PASSIVE = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } busState_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DMA  = 2'd1,
    SRC_EU   = 2'd2,
    SRC_PF   = 2'd3
  } busSrc_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    load;        // latch the attributes of loadSrc at this edge
    busSrc_e loadSrc;
    busSrc_e owner;       // requester of the cycle in progress
    logic    addrPhase;   // T1
    logic    strobePhase; // T2 or T3
    logic    endPhase;    // T4
    logic    capture;     // last T3 edge: sample read data
  } seqCtl_t;

  function automatic logic [STAT_W-1:0] cycleCode(input logic isPf,
                                                  input logic isIo,
                                                  input logic isWr);
    if (isPf)      return CODE_FETCH;
    else if (isIo) return isWr ? CODE_IO_WR : CODE_IO_RD;
    else           return isWr ? CODE_MEM_WR : CODE_MEM_RD;
  endfunction

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ready,
  input  logic    dmaReq,
  input  logic    euReq,
  input  logic    pfReq,
  output seqCtl_t ctl
);

  localparam int NSRC = 3;

  busState_e state, stateNext;
  busSrc_e   owner, pick;
  logic [NSRC-1:0] reqMasked;
  logic      atBoundary, doLoad;

  // owner of a finishing cycle is hidden so it is not granted twice
  always_comb begin
    reqMasked = {pfReq, euReq, dmaReq};
    if (state == ST_T4) begin
      case (owner)
        SRC_DMA: reqMasked[0] = 1'b0;
        SRC_EU:  reqMasked[1] = 1'b0;
        SRC_PF:  reqMasked[2] = 1'b0;
        default: ;
      endcase
    end
    if (reqMasked[0])      pick = SRC_DMA;
    else if (reqMasked[1]) pick = SRC_EU;
    else if (reqMasked[2]) pick = SRC_PF;
    else                   pick = SRC_NONE;
  end

  assign atBoundary = (state == ST_IDLE) || (state == ST_T4);
  assign doLoad     = atBoundary && (pick != SRC_NONE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: stateNext = doLoad ? ST_T1 : ST_IDLE;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3:   stateNext = ready ? ST_T4 : ST_T3;
      ST_T4:   stateNext = doLoad ? ST_T1 : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      owner <= SRC_NONE;
    end else begin
      state <= stateNext;
      if (doLoad)              owner <= pick;
      else if (state == ST_T4) owner <= SRC_NONE;
    end
  end

  always_comb begin
    ctl.load        = doLoad;
    ctl.loadSrc     = pick;
    ctl.owner       = owner;
    ctl.addrPhase   = (state == ST_T1);
    ctl.strobePhase = (state == ST_T2) || (state == ST_T3);
    ctl.endPhase    = (state == ST_T4);
    ctl.capture     = (state == ST_T3) && ready;
  end

endmodule

// File: rtl/bus_seq_dp.sv
module bus_seq_dp
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int IO_HI_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              dmaIo,
  input  logic              dmaWrite,
  input  logic              dmaByte,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0] dmaWdata,
  input  logic              euIo,
  input  logic              euWrite,
  input  logic              euByte,
  input  logic [ADDR_W-1:0] euAddr,
  input  logic [DATA_W-1:0] euWdata,
  input  logic [ADDR_W-1:0] pfAddr,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic              rdN,
  output logic              wrN,
  output logic              bheN,
  output logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pfqData,
  output logic              dmaDone,
  output logic              euDone,
  output logic              pfqWrEn
);

  localparam int LO_W     = ADDR_W - IO_HI_W;
  localparam int DATA_PAD = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] curAddr, selAddr;
  logic [DATA_W-1:0] curWdata, selWdata, rdDataQ;
  logic curIo, curWr, curByte, curPf;
  logic selIo, selWr, selByte, selPf;
  logic inCycle;

  // request attribute mux for the source being granted
  always_comb begin
    selAddr  = pfAddr;
    selWdata = '0;
    selIo    = 1'b0;
    selWr    = 1'b0;
    selByte  = 1'b0;
    selPf    = 1'b0;
    case (ctl.loadSrc)
      SRC_DMA: begin
        selAddr = dmaAddr; selWdata = dmaWdata;
        selIo = dmaIo; selWr = dmaWrite; selByte = dmaByte;
      end
      SRC_EU: begin
        selAddr = euAddr; selWdata = euWdata;
        selIo = euIo; selWr = euWrite; selByte = euByte;
      end
      SRC_PF:  selPf = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      curIo    <= 1'b0;
      curWr    <= 1'b0;
      curByte  <= 1'b0;
      curPf    <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      if (ctl.load) begin
        curAddr  <= selAddr;
        curWdata <= selWdata;
        curIo    <= selIo;
        curWr    <= selWr;
        curByte  <= selByte;
        curPf    <= selPf;
      end
      if (ctl.capture && !curWr) rdDataQ <= adIn;
    end
  end

  assign inCycle = ctl.addrPhase || ctl.strobePhase || ctl.endPhase;

  // address phase, then data phase; idle keeps the last write data
  always_comb begin
    if (ctl.addrPhase) begin
      adOut = {curIo ? {IO_HI_W{1'b0}} : curAddr[ADDR_W-1 -: IO_HI_W],
               curAddr[LO_W-1:0]};
      adOe  = 1'b1;
    end else begin
      adOut = {{DATA_PAD{1'b0}}, curWdata};
      adOe  = curWr;
    end
  end

  assign rdN    = !(ctl.strobePhase && !curWr);
  assign wrN    = !(ctl.strobePhase && curWr);
  assign bheN   = inCycle ? (curByte && !curAddr[0]) : 1'b1;
  assign status = (ctl.addrPhase || ctl.strobePhase)
                  ? cycleCode(curPf, curIo, curWr) : CODE_PASSIVE;

  assign rdData  = rdDataQ;
  assign pfqData = rdDataQ;
  assign dmaDone = ctl.endPhase && (ctl.owner == SRC_DMA);
  assign euDone  = ctl.endPhase && (ctl.owner == SRC_EU);
  assign pfqWrEn = ctl.endPhase && (ctl.owner == SRC_PF);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int IO_HI_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ready,
  input  logic              dmaReq,
  input  logic              dmaIo,
  input  logic              dmaWrite,
  input  logic              dmaByte,
  input  logic [ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0] dmaWdata,
  output logic              dmaDone,
  input  logic              euReq,
  input  logic              euIo,
  input  logic              euWrite,
  input  logic              euByte,
  input  logic [ADDR_W-1:0] euAddr,
  input  logic [DATA_W-1:0] euWdata,
  output logic              euDone,
  output logic [DATA_W-1:0] rdData,
  input  logic              pfReq,
  input  logic [ADDR_W-1:0] pfAddr,
  output logic              pfqWrEn,
  output logic [DATA_W-1:0] pfqData,
  input  logic [DATA_W-1:0] adIn,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              bheN,
  output logic [2:0]        status
);

  seqCtl_t ctl;

  bus_seq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ready  (ready),
    .dmaReq (dmaReq),
    .euReq  (euReq),
    .pfReq  (pfReq),
    .ctl    (ctl)
  );

  bus_seq_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IO_HI_W (IO_HI_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dmaIo    (dmaIo),
    .dmaWrite (dmaWrite),
    .dmaByte  (dmaByte),
    .dmaAddr  (dmaAddr),
    .dmaWdata (dmaWdata),
    .euIo     (euIo),
    .euWrite  (euWrite),
    .euByte   (euByte),
    .euAddr   (euAddr),
    .euWdata  (euWdata),
    .pfAddr   (pfAddr),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .rdN      (rdN),
    .wrN      (wrN),
    .bheN     (bheN),
    .status   (status),
    .rdData   (rdData),
    .pfqData  (pfqData),
    .dmaDone  (dmaDone),
    .euDone   (euDone),
    .pfqWrEn  (pfqWrEn)
  );

  assign ale = ctl.addrPhase;

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int ADDR_W  = 20,
  parameter int IO_HI_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              ale,
  input logic              rdN,
  input logic              wrN,
  input logic              adOe,
  input logic [ADDR_W-1:0] adOut,
  input logic [2:0]        status,
  input logic              bheN,
  input logic              dmaDone,
  input logic              euDone,
  input logic              pfqWrEn
);

  logic anyDone, strobeLow;
  assign anyDone   = dmaDone || euDone || pfqWrEn;
  assign strobeLow = !rdN || !wrN;

  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  p_ale_then_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (!ale && strobeLow));

  p_release_done_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rdN) || $rose(wrN)) |-> anyDone);

  p_passive_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && rdN && wrN) |-> (status == 3'b111));

  p_io_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ale && (status == 3'b001 || status == 3'b010))
      |-> (adOut[ADDR_W-1 -: IO_HI_W] == '0));

  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobeLow && !ready) |=> strobeLow);

  p_read_float_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN || $rose(wrN)) |-> adOe);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN && !anyDone));

  p_single_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaDone, euDone, pfqWrEn}));

  p_bhe_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && rdN && wrN && !anyDone) |-> bheN);

endmodule

bind bus_cycle_seq bus_seq_chk #(
  .ADDR_W  (ADDR_W),
  .IO_HI_W (IO_HI_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ready   (ready),
  .ale     (ale),
  .rdN     (rdN),
  .wrN     (wrN),
  .adOe    (adOe),
  .adOut   (adOut),
  .status  (status),
  .bheN    (bheN),
  .dmaDone (dmaDone),
  .euDone  (euDone),
  .pfqWrEn (pfqWrEn)
);

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ready = 1'b1;
  logic dmaReq = 0, dmaIo = 0, dmaWrite = 0, dmaByte = 0;
  logic [19:0] dmaAddr = '0;
  logic [15:0] dmaWdata = '0;
  logic euReq = 0, euIo = 0, euWrite = 0, euByte = 0;
  logic [19:0] euAddr = '0;
  logic [15:0] euWdata = '0;
  logic pfReq = 0;
  logic [19:0] pfAddr = '0;
  logic [15:0] adIn = '0;
  logic dmaDone, euDone, pfqWrEn, adOe, ale, rdN, wrN, bheN;
  logic [15:0] rdData, pfqData;
  logic [19:0] adOut;
  logic [2:0] status;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_cycle_seq u_dut (
    .clk(clk), .rstN(rstN), .ready(ready),
    .dmaReq(dmaReq), .dmaIo(dmaIo), .dmaWrite(dmaWrite), .dmaByte(dmaByte),
    .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaDone(dmaDone),
    .euReq(euReq), .euIo(euIo), .euWrite(euWrite), .euByte(euByte),
    .euAddr(euAddr), .euWdata(euWdata), .euDone(euDone),
    .rdData(rdData), .pfReq(pfReq), .pfAddr(pfAddr),
    .pfqWrEn(pfqWrEn), .pfqData(pfqData),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .ale(ale),
    .rdN(rdN), .wrN(wrN), .bheN(bheN), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] expCode(input int src, input bit io, input bit wr);
    if (src == 2) return 3'b100;
    if (io) return wr ? 3'b010 : 3'b001;
    return wr ? 3'b110 : 3'b101;
  endfunction

  function automatic logic [19:0] expAddr(input bit io, input logic [19:0] a);
    return io ? {4'h0, a[15:0]} : a;
  endfunction

  function automatic logic expBhe(input bit byt, input logic a0);
    return byt && !a0;
  endfunction

  function automatic logic [2:0] expDone(input int src);
    return (src == 0) ? 3'b100 : (src == 1) ? 3'b010 : 3'b001;
  endfunction

  task automatic setReq(input int src, input bit on, input bit io, input bit wr,
                        input bit byt, input logic [19:0] a, input logic [15:0] d);
    case (src)
      0: begin dmaReq = on; dmaIo = io; dmaWrite = wr; dmaByte = byt; dmaAddr = a; dmaWdata = d; end
      1: begin euReq = on; euIo = io; euWrite = wr; euByte = byt; euAddr = a; euWdata = d; end
      default: begin pfReq = on; pfAddr = a; end
    endcase
  endtask

  task automatic runXfer(input int src, input bit ioIn, input bit wrIn, input bit byIn,
                         input logic [19:0] a, input logic [15:0] d,
                         input logic [15:0] rd, input int waits);
    bit io, wr, byt;
    io  = (src == 2) ? 1'b0 : ioIn;
    wr  = (src == 2) ? 1'b0 : wrIn;
    byt = (src == 2) ? 1'b0 : byIn;
    @(negedge clk);
    setReq(src, 1, io, wr, byt, a, d);
    @(negedge clk);  // T1
    chk("R1 ale in T1", ale, 1);
    chk("R2 code in T1", status, expCode(src, io, wr));
    chk("R3 address in T1", adOut, expAddr(io, a));
    chk("R7 strobes idle in T1", {rdN, wrN}, 2'b11);
    chk("R10 bhe in T1", bheN, expBhe(byt, a[0]));
    @(negedge clk);  // T2
    chk("R1 strobe in T2", {rdN, wrN}, wr ? 2'b10 : 2'b01);
    chk("R2 code in T2", status, expCode(src, io, wr));
    if (wr) begin
      chk("R6 drive in T2", adOe, 1);
      chk("R6 data in T2", adOut, {4'h0, d});
    end else chk("R5 float in T2", adOe, 0);
    for (int k = 0; k <= waits; k++) begin
      @(negedge clk);  // T3
      chk("R4 strobe held in T3", {rdN, wrN}, wr ? 2'b10 : 2'b01);
      ready = (k == waits);
      adIn  = (k == waits) ? rd : ~rd;
    end
    @(negedge clk);  // T4
    ready = 1'b1;
    chk("R1 strobes released in T4", {rdN, wrN}, 2'b11);
    chk("R2 passive in T4", status, 3'b111);
    chk("R9 done routing", {dmaDone, euDone, pfqWrEn}, expDone(src));
    if (!wr) chk("R4 read data", (src == 2) ? pfqData : rdData, rd);
    chk("R10 bhe in T4", bheN, expBhe(byt, a[0]));
    if (wr) chk("R6 drive in T4", adOe, 1);
    else    chk("R5 float in T4", adOe, 0);
    setReq(src, 0, io, wr, byt, a, d);
    @(negedge clk);  // idle
    chk("R7 idle strobes", {ale, rdN, wrN}, 3'b011);
    chk("R2 passive idle", status, 3'b111);
    chk("R10 bhe idle", bheN, 1);
    chk("R9 no done idle", {dmaDone, euDone, pfqWrEn}, 3'b000);
    if (wr) begin
      chk("R6 idle keeps drive", adOe, 1);
      chk("R6 idle keeps data", adOut[15:0], d);
    end else chk("R5 idle floats", adOe, 0);
  endtask

  initial begin
    void'($urandom(32'd7151));
    repeat (3) @(negedge clk);
    chk("R11 reset status", status, 3'b111);
    chk("R11 reset strobes", {ale, rdN, wrN, bheN}, 4'b0111);
    chk("R11 reset oe", adOe, 0);
    chk("R11 reset done", {dmaDone, euDone, pfqWrEn}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    runXfer(1, 1, 0, 0, 20'hF1234, 16'h0, 16'hBEEF, 0);  // I/O read, upper nibble nonzero
    runXfer(1, 0, 0, 1, 20'hF1234, 16'h0, 16'h00A5, 5);  // memory even byte, long wait
    runXfer(0, 1, 1, 1, 20'hA0011, 16'h5A5A, 16'h0, 2);  // DMA I/O write odd byte
    runXfer(2, 0, 0, 0, 20'h3FFFE, 16'h0, 16'hC3C3, 1);  // prefetch
    runXfer(0, 0, 1, 0, 20'h80000, 16'h1357, 16'h0, 0);  // memory write word

    // R8: three-way contention, back-to-back grants
    begin
      logic [19:0] seen [3];
      int aleAt [3];
      int n = 0;
      @(negedge clk);
      setReq(2, 1, 0, 0, 0, 20'h22222, 16'h0);
      setReq(1, 1, 0, 0, 0, 20'h11111, 16'h0);
      setReq(0, 1, 0, 0, 0, 20'h00F00, 16'h0);
      for (int c = 1; c <= 12; c++) begin
        @(negedge clk);
        if (ale && n < 3) begin seen[n] = adOut; aleAt[n] = c; n++; end
        if (dmaDone) dmaReq = 0;
        if (euDone)  euReq = 0;
        if (pfqWrEn) pfReq = 0;
        if (c == 12) chk("R8 last done back-to-back", pfqWrEn, 1);
      end
      chk("R8 grant count", n, 3);
      chk("R8 first DMA", seen[0], 20'h00F00);
      chk("R8 second EU", seen[1], 20'h11111);
      chk("R8 third prefetch", seen[2], 20'h22222);
      chk("R8 T1 spacing a", aleAt[1], 5);
      chk("R8 T1 spacing b", aleAt[2], 9);
      @(negedge clk);
    end

    // R8: request raised mid-cycle waits for the boundary
    begin
      @(negedge clk);
      setReq(1, 1, 0, 0, 0, 20'h4C0DE, 16'h0);
      for (int c = 1; c <= 9; c++) begin
        @(negedge clk);
        if (c == 2) setReq(0, 1, 1, 1, 0, 20'hF7788, 16'h9ABC);
        if (c == 3) chk("R8 current cycle keeps strobe", {rdN, ale}, 2'b00);
        if (c == 4) chk("R8 EU finishes first", euDone, 1);
        if (c == 5) begin
          chk("R8 DMA T1 at boundary", ale, 1);
          chk("R3 DMA I/O address", adOut, 20'h07788);
          chk("R2 I/O write code", status, 3'b010);
        end
        if (c == 8) chk("R9 DMA done", dmaDone, 1);
        if (euDone)  euReq = 0;
        if (dmaDone) dmaReq = 0;
      end
      @(negedge clk);
    end

    // seeded random traffic
    for (int i = 0; i < 40; i++) begin
      int src;
      src = int'($urandom_range(2, 0));
      runXfer(src, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
              1'($urandom_range(1, 0)), 20'($urandom), 16'($urandom),
              16'($urandom), int'($urandom_range(3, 0)));
    end

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(100000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule